// File: doc/BRIEF.md
# Counter-DAC Overcurrent Threshold Sampler

This block turns an analog overcurrent setting into a stored digital code. After a start request it runs a code counter upward from zero, one step per step tick. An external DAC converts that code to a voltage, and an external comparator checks the result against the voltage being sampled. On the first tick at which the comparator reports that the DAC output has reached the sample, counting stops. The code is then kept in a hold register and done is raised. The overcurrent comparator uses the held code from then on.

The search is a single upward ramp, so a higher setting takes more ticks to find. With a 6-bit code and a tick about every 53 µs, the whole range fits in roughly 3.4 ms. The held code is digital, so it does not drift while bias stays good. When the POR-good input drops, the result is cleared and the block returns to idle. It then waits for the next start.

Top module: `ocp_ramp_sh`

## Requirements
- R1: While rst_n is low, and in the cycle after any edge with por_ok low, dac_code, held_code and done are all zero.
- R2: A start pulse seen in idle with por_ok high begins sampling with dac_code at 0. During sampling, each step_tick that does not stop the ramp raises dac_code by exactly one in the following cycle. With no tick, dac_code is unchanged.
- R3: A step_tick during sampling with cmp_hi high stops the ramp. In the next cycle done is 1 and held_code equals the dac_code present at that tick. cmp_hi high without a tick has no effect.
- R4: A step_tick during sampling when dac_code is at full scale (all ones, 63 by default) and cmp_hi is low ends the ramp. held_code becomes full scale and done is 1 in the next cycle.
- R5: Once done is 1 and por_ok stays high, held_code, dac_code and done do not change. Further start pulses, step ticks and comparator changes are all ignored.
- R6: A start pulse while por_ok is low is ignored: no sampling begins and dac_code stays 0.
- R7: After por_ok returns high, a new start performs a fresh sample from code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Bias above power-on threshold; low clears the result |
| start | input | 1 | Begin a sample (acted on in idle only) |
| step_tick | input | 1 | One-cycle pulse that paces the ramp |
| cmp_hi | input | 1 | Comparator: DAC output at or above the sampled voltage |
| dac_code | output | CODE_W | Code driven to the external DAC |
| held_code | output | CODE_W | Stored threshold code |
| done | output | 1 | Sample complete, held_code valid |

## Verification
Every result is due one clock edge after the input that causes it: a tick moves dac_code in the next cycle, and a stopping tick sets done and held_code in the next cycle. Clearing by por_ok also appears one cycle after the edge that sees it low. The bench drives ticks and the comparator on the falling edge, from the dac_code already visible. It checks each output on the falling edge after the rising edge that should update it, so a value is never read in the cycle it changes. Comparator thresholds come from a fixed-seed random stream, some of them beyond full scale. The expected code and tick count are computed from the threshold alone.

// File: rtl/ocp_sh_pkg.sv
package ocp_sh_pkg;
  typedef enum logic [1:0] {
    SH_IDLE   = 2'd0,
    SH_SAMPLE = 2'd1,
    SH_HOLD   = 2'd2
  } sh_state_e;

  // Full scale of a code of the given width.
  function automatic int unsigned code_top(int unsigned w);
    return (32'd1 << w) - 32'd1;
  endfunction

  // Whether a ramp tick ends the search.
  function automatic logic tick_stops(logic cmp, logic at_top);
    return cmp | at_top;
  endfunction
endpackage

// File: rtl/ocp_sh_ctrl.sv
module ocp_sh_ctrl
  import ocp_sh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic start,
  input  logic step_tick,
  input  logic cmp_hi,
  input  logic at_top,
  output logic clr_cnt,
  output logic inc_cnt,
  output logic load_hold,
  output logic clr_hold,
  output logic sampling
);
  sh_state_e st_q, st_d;
  logic      stop_now;

  assign sampling  = (st_q == SH_SAMPLE);
  assign stop_now  = tick_stops(cmp_hi, at_top);
  assign clr_cnt   = !por_ok || (st_q == SH_IDLE);
  assign inc_cnt   = por_ok && sampling && step_tick && !stop_now;
  assign load_hold = por_ok && sampling && step_tick && stop_now;
  assign clr_hold  = !por_ok;

  always_comb begin
    st_d = st_q;
    if (!por_ok) begin
      st_d = SH_IDLE;
    end else begin
      unique case (st_q)
        SH_IDLE:   if (start) st_d = SH_SAMPLE;
        SH_SAMPLE: if (load_hold) st_d = SH_HOLD;
        SH_HOLD:   st_d = SH_HOLD;
        default:   st_d = SH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SH_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/ocp_sh_counter.sv
module ocp_sh_counter #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [CODE_W-1:0] cnt,
  output logic              at_top
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  assign at_top = (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (inc && !at_top) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ocp_sh_hold.sv
module ocp_sh_hold #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q,
  output logic              valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (clr) begin
      q     <= '0;
      valid <= 1'b0;
    end else if (load) begin
      q     <= d;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ocp_ramp_sh.sv
module ocp_ramp_sh
  import ocp_sh_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              start,
  input  logic              step_tick,
  input  logic              cmp_hi,
  output logic [CODE_W-1:0] dac_code,
  output logic [CODE_W-1:0] held_code,
  output logic              done
);
  localparam logic [CODE_W-1:0] CODE_TOP = CODE_W'(code_top(CODE_W));

  logic clr_cnt, inc_cnt, load_hold, clr_hold, sampling, at_top;

  // Named events for the assertions.
  logic step_evt, trip_evt, top_evt;
  assign step_evt = inc_cnt;
  assign trip_evt = load_hold && cmp_hi;
  assign top_evt  = load_hold && !cmp_hi;

  ocp_sh_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .start(start),
    .step_tick(step_tick), .cmp_hi(cmp_hi), .at_top(at_top),
    .clr_cnt(clr_cnt), .inc_cnt(inc_cnt), .load_hold(load_hold),
    .clr_hold(clr_hold), .sampling(sampling)
  );

  ocp_sh_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cnt), .inc(inc_cnt),
    .cnt(dac_code), .at_top(at_top)
  );

  ocp_sh_hold #(.CODE_W(CODE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr_hold), .load(load_hold),
    .d(dac_code), .q(held_code), .valid(done)
  );

  AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (!done && held_code == '0 && dac_code == '0)); // R1

  AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
    step_evt |=> (dac_code == $past(dac_code) + 1'b1)); // R2

  AST_NO_TICK_STILL: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
    (sampling && !step_tick) |=> $stable(dac_code)); // R2

  AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
    trip_evt |=> (done && held_code == $past(dac_code))); // R3

  AST_TOP_LATCH: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
    top_evt |=> (done && held_code == CODE_TOP)); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !por_ok)
    done |=> (done && $stable(held_code) && $stable(dac_code))); // R5

  AST_NO_SAMPLE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sampling && done)); // R5
endmodule

// File: tb/test_ocp_ramp_sh.sv
`timescale 1ns/1ps
module test_ocp_ramp_sh;
  localparam int W   = 6;
  localparam int TOP = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         por_ok = 1'b0;
  logic         start = 1'b0;
  logic         step_tick = 1'b0;
  logic         cmp_hi = 1'b0;
  logic [W-1:0] dac_code;
  logic [W-1:0] held_code;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ocp_ramp_sh #(.CODE_W(W)) i_ocp_ramp_sh (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .start(start),
    .step_tick(step_tick), .cmp_hi(cmp_hi), .dac_code(dac_code),
    .held_code(held_code), .done(done)
  );

  function automatic int exp_code(int thr);
    return (thr > TOP) ? TOP : thr;
  endfunction

  function automatic int exp_ticks(int thr);
    return exp_code(thr) + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Ramp with a comparator that trips at code thr; random tick spacing.
  task automatic run_sample(int thr, string req);
    int ticks = 0;
    int exp_dac = 0;
    int guard = 0;
    pulse_start();
    forever begin
      if (done) break;
      chk("R2 dac step", int'(dac_code), exp_dac);
      cmp_hi    = (int'(dac_code) >= thr);
      step_tick = ($urandom % 3) == 0;
      if (step_tick) begin
        ticks++;
        if (!cmp_hi && int'(dac_code) != TOP) exp_dac++;
      end
      @(negedge clk);
      step_tick = 1'b0;
      guard++;
      if (guard > 2000) break;
    end
    cmp_hi = 1'b0;
    chk({req, " done"}, int'(done), 1);
    chk({req, " held"}, int'(held_code), exp_code(thr));
    chk({req, " ticks"}, ticks, exp_ticks(thr));
  endtask

  task automatic lose_por();
    @(negedge clk); por_ok = 1'b0;
    @(negedge clk);
    chk("R1 por clear done", int'(done), 0);
    chk("R1 por clear held", int'(held_code), 0);
    chk("R1 por clear dac", int'(dac_code), 0);
    por_ok = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset dac", int'(dac_code), 0);
    chk("R1 reset held", int'(held_code), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    por_ok = 1'b1;
    @(negedge clk);

    // R3: comparator high without a tick does nothing
    pulse_start();
    cmp_hi = 1'b1;
    repeat (6) @(negedge clk);
    chk("R3 no tick no stop", int'(done), 0);
    chk("R3 no tick dac", int'(dac_code), 0);
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
    cmp_hi = 1'b0;
    chk("R3 trip at zero done", int'(done), 1);
    chk("R3 trip at zero held", int'(held_code), 0);

    // R5: start, ticks and comparator ignored after done
    pulse_start();
    for (int i = 0; i < 8; i++) begin
      step_tick = 1'b1;
      cmp_hi = i[0];
      @(negedge clk);
    end
    step_tick = 1'b0;
    cmp_hi = 1'b0;
    chk("R5 held kept", int'(held_code), 0);
    chk("R5 dac kept", int'(dac_code), 0);
    chk("R5 done kept", int'(done), 1);

    lose_por();

    // R4: no trip, full scale
    run_sample(TOP + 5, "R4 full");
    lose_por();
    run_sample(TOP, "R3 trip at top");
    lose_por();

    // R6: start while por low
    @(negedge clk); por_ok = 1'b0;
    pulse_start();
    for (int i = 0; i < 4; i++) begin
      step_tick = 1'b1;
      @(negedge clk);
    end
    step_tick = 1'b0;
    chk("R6 no ramp dac", int'(dac_code), 0);
    chk("R6 no ramp done", int'(done), 0);
    por_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 still idle", int'(dac_code) + int'(done), 0);

    // R7: repeated random samples
    for (int n = 0; n < 25; n++) begin
      int thr;
      thr = int'($urandom % (TOP + 8));
      run_sample(thr, "R7 fresh");
      lose_por();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule